// File: doc/BRIEF.md
# Parallel Printer Port with Acknowledge Interrupt

This block connects a host register bus to a parallel printer. Software writes a character into an 8-bit output latch. A write to a separate trigger address then starts a strobe sequence. The sequence waits one clock so that the data has settled, then drives an active-low strobe for a fixed number of clocks. The printer's busy, acknowledge and error lines are brought into the clock domain and can be read through a 16-bit status word. A polled driver reads the high byte of that word on its own.

An interrupt-driven driver sets an enable bit in the status word. From then on, each active edge of the printer acknowledge sets a pending flag, which drives the interrupt request toward the system's priority encoder. The interrupt controller removes the request with a clear strobe once it has serviced it. An input selects whether the acknowledge edge that counts is rising or falling.

Top module: `prn_port`

## Requirements
- R1: In reset and on the first cycle after it, `prn_strobe_n` is high, `prn_data` is 0x00, `irq_req` is low and the enable bit reads 0.
- R2: Only addresses whose upper bits match parameter `BASE` (bits ADDR_W-1:4) reach the block. A write elsewhere changes nothing, and a read elsewhere returns 0x0000. Offsets 0x0 to 0xB read 0x0000.
- R3: A write at offset 0xE stores `bus_wdata[7:0]` into `prn_data` at the next edge. A read at offset 0xE returns that byte in bits 7:0, with bits 15:8 zero.
- R4: A write at offset 0xF is followed by one cycle with the strobe high. `prn_strobe_n` then stays low for exactly `STB_CYCLES` cycles (default 4) and returns high.
- R5: From the trigger edge until the strobe is high again, writes at offsets 0xE and 0xF are ignored, so `prn_data` holds steady throughout the low pulse.
- R6: A read at offset 0xC returns bit 15 = error, bit 9 = acknowledge, bit 8 = busy, bit 7 = pending and bit 6 = enable, with every other bit 0. The three line bits follow their pins (acknowledge not inverted) two clock edges late.
- R7: A read at offset 0xD returns status bits 15:8 in bits 7:0, with bits 15:8 zero.
- R8: A write at offset 0xC sets the enable bit from `bus_wdata[6]`. A write at offset 0xD leaves the enable bit unchanged.
- R9: With enable set and `ack_inv` = 0, a rising edge on `prn_ack` raises `irq_req` three edges after the pin changes. The request stays high until it is cleared.
- R10: With `ack_inv` = 1, the falling edge of `prn_ack` is the active edge instead.
- R11: While the enable bit is 0, acknowledge edges set nothing. Writing enable to 0 drops a pending request at the next edge.
- R12: `irq_clr` high drops the pending flag at the next edge. If an active edge arrives in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read enable |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational from address and state |
| prn_data | output | 8 | Character lines to the printer |
| prn_strobe_n | output | 1 | Active-low data strobe |
| prn_busy | input | 1 | Printer busy, asynchronous |
| prn_ack | input | 1 | Printer acknowledge, asynchronous |
| prn_err | input | 1 | Printer error, asynchronous |
| ack_inv | input | 1 | 1 selects the falling acknowledge edge |
| irq_clr | input | 1 | Clear strobe from the interrupt controller |
| irq_req | output | 1 | Pending printer interrupt |

## Verification
A wrong strobe counter shows up as a strobe pulse of the wrong length, or as a shifted start cycle, within `STB_CYCLES`+2 cycles of the trigger write. A fault in the acknowledge synchronizer or edge detector moves the rise of `irq_req` off its three-edge slot, or produces a request while the enable is clear, and this is visible on the next cycle. A latch or enable bit that takes a stray write appears on the next read of 0xC or 0xE, or on `prn_data` at once. Comparing every output against a behavioural model on every clock exposes each of these faults in the cycle where it first appears.

// File: rtl/prn_port_pkg.sv
package prn_port_pkg;

    localparam int OFS_W = 4;

    localparam logic [OFS_W-1:0] OFS_STAT_LO = 4'hC;
    localparam logic [OFS_W-1:0] OFS_STAT_HI = 4'hD;
    localparam logic [OFS_W-1:0] OFS_DATA    = 4'hE;
    localparam logic [OFS_W-1:0] OFS_STROBE  = 4'hF;

    localparam int EN_BIT = 6;

    typedef enum logic [1:0] {
        STB_IDLE  = 2'd0,
        STB_SETUP = 2'd1,
        STB_LOW   = 2'd2
    } stb_state_e;

    // synchronized printer lines, bit order fixed for the synchronizer vector
    typedef struct packed {
        logic err;
        logic ack;
        logic busy;
    } line_stat_t;

    typedef struct packed {
        logic             hit;
        logic             wr_stat;
        logic             wr_data;
        logic             wr_strobe;
        logic [OFS_W-1:0] ofs;
    } bus_op_t;

    function automatic logic [15:0] pack_status(line_stat_t l, logic pend, logic en);
        return {l.err, 5'b0, l.ack, l.busy, pend, en, 6'b0};
    endfunction

endpackage

// File: rtl/prn_sync.sv
module prn_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // two flops per line, one chain per bit
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic s1_q, s2_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                s1_q <= 1'b0;
                s2_q <= 1'b0;
            end else begin
                s1_q <= d[i];
                s2_q <= s1_q;
            end
        end
        assign q[i] = s2_q;
    end
endmodule

// File: rtl/prn_strobe_gen.sv
module prn_strobe_gen
    import prn_port_pkg::*;
#(
    parameter int STB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy,
    output logic strobe_n
);
    localparam int CNT_W = (STB_CYCLES > 1) ? $clog2(STB_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(STB_CYCLES - 1);

    stb_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= STB_IDLE;
            cnt_q   <= '0;
        end else begin
            unique case (state_q)
                STB_IDLE: begin
                    if (start) state_q <= STB_SETUP;
                end
                STB_SETUP: begin
                    state_q <= STB_LOW;
                    cnt_q   <= CNT_LOAD;
                end
                STB_LOW: begin
                    if (cnt_q == '0) state_q <= STB_IDLE;
                    else             cnt_q   <= cnt_q - 1'b1;
                end
                default: state_q <= STB_IDLE;
            endcase
        end
    end

    assign busy     = (state_q != STB_IDLE);
    assign strobe_n = (state_q != STB_LOW);
endmodule

// File: rtl/prn_irq.sv
module prn_irq (
    input  logic clk,
    input  logic rst,
    input  logic ack_sync,
    input  logic ack_inv,
    input  logic en_wr,
    input  logic en_val,
    input  logic irq_clr,
    output logic en,
    output logic pend,
    output logic rise
);
    logic lvl;
    logic lvl_q, en_q, pend_q;

    assign lvl  = ack_sync ^ ack_inv;
    assign rise = lvl & ~lvl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q  <= 1'b0;
            en_q   <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            lvl_q <= lvl;
            if (en_wr) en_q <= en_val;
            if (!en_q)        pend_q <= 1'b0;
            else if (rise)    pend_q <= 1'b1;
            else if (irq_clr) pend_q <= 1'b0;
        end
    end

    assign en   = en_q;
    assign pend = pend_q;
endmodule

// File: rtl/prn_port.sv
module prn_port
    import prn_port_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] BASE       = 16'hFF40,
    parameter int                STB_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic [7:0]        prn_data,
    output logic              prn_strobe_n,
    input  logic              prn_busy,
    input  logic              prn_ack,
    input  logic              prn_err,
    input  logic              ack_inv,
    input  logic              irq_clr,
    output logic              irq_req
);
    localparam int TAG_W = ADDR_W - OFS_W;
    localparam logic [TAG_W-1:0] BASE_TAG = BASE[ADDR_W-1:OFS_W];

    bus_op_t    op;
    line_stat_t lines;
    logic [2:0] lines_vec;
    logic       stb_busy;
    logic       en_q, pend_q, ack_rise;
    logic [7:0] data_q;
    logic [15:0] status;
    logic       unused_wbits;

    assign unused_wbits = ^{bus_wdata[15:8], bus_wdata[7], bus_wdata[5:0]};

    // address decode
    always_comb begin
        op.ofs       = bus_addr[OFS_W-1:0];
        op.hit       = (bus_addr[ADDR_W-1:OFS_W] == BASE_TAG);
        op.wr_stat   = op.hit && bus_wr && (op.ofs == OFS_STAT_LO);
        op.wr_data   = op.hit && bus_wr && (op.ofs == OFS_DATA)   && !stb_busy;
        op.wr_strobe = op.hit && bus_wr && (op.ofs == OFS_STROBE) && !stb_busy;
    end

    prn_sync #(.W(3)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   ({prn_err, prn_ack, prn_busy}),
        .q   (lines_vec)
    );
    assign lines = line_stat_t'(lines_vec);

    prn_strobe_gen #(.STB_CYCLES(STB_CYCLES)) stb_i (
        .clk      (clk),
        .rst      (rst),
        .start    (op.wr_strobe),
        .busy     (stb_busy),
        .strobe_n (prn_strobe_n)
    );

    prn_irq irq_i (
        .clk      (clk),
        .rst      (rst),
        .ack_sync (lines.ack),
        .ack_inv  (ack_inv),
        .en_wr    (op.wr_stat),
        .en_val   (bus_wdata[EN_BIT]),
        .irq_clr  (irq_clr),
        .en       (en_q),
        .pend     (pend_q),
        .rise     (ack_rise)
    );

    always_ff @(posedge clk) begin
        if (rst)             data_q <= '0;
        else if (op.wr_data) data_q <= bus_wdata[7:0];
    end

    assign status = pack_status(lines, pend_q, en_q);

    always_comb begin
        bus_rdata = '0;
        if (bus_rd && op.hit) begin
            unique case (op.ofs)
                OFS_STAT_LO: bus_rdata = status;
                OFS_STAT_HI: bus_rdata = {8'h00, status[15:8]};
                OFS_DATA:    bus_rdata = {8'h00, data_q};
                default:     bus_rdata = '0;
            endcase
        end
    end

    assign prn_data = data_q;
    assign irq_req  = pend_q;
endmodule

// File: rtl/prn_port_chk.sv
module prn_port_chk #(
    parameter int STB_CYCLES = 4
) (
    input logic       clk,
    input logic       rst,
    input logic       strobe_n,
    input logic [7:0] data_out,
    input logic       irq_req,
    input logic       irq_clr,
    input logic       en,
    input logic       rise
);
    logic [15:0] low_cnt;

    always_ff @(posedge clk) begin
        if (rst || strobe_n) low_cnt <= '0;
        else                 low_cnt <= low_cnt + 1'b1;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (strobe_n && !irq_req && !en)); // R1

    AST_STB_WIDTH: assert property (@(posedge clk) disable iff (rst)
        $rose(strobe_n) |-> (low_cnt == 16'(STB_CYCLES))); // R4

    AST_STB_TOO_LONG: assert property (@(posedge clk) disable iff (rst)
        !strobe_n |-> (low_cnt < 16'(STB_CYCLES))); // R4

    AST_DATA_HELD: assert property (@(posedge clk) disable iff (rst)
        (!strobe_n && !$past(rst)) |-> $stable(data_out)); // R5

    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_req) |-> $past(en)); // R11

    AST_DISABLE_DROPS: assert property (@(posedge clk) disable iff (rst)
        !$past(en) |-> !irq_req); // R11

    AST_CLR_DROPS: assert property (@(posedge clk) disable iff (rst)
        ($past(irq_clr) && !$past(rise)) |-> !irq_req); // R12

    AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
        ($past(rise) && $past(en)) |-> irq_req); // R12
endmodule

bind prn_port prn_port_chk #(.STB_CYCLES(STB_CYCLES)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .strobe_n (prn_strobe_n),
    .data_out (prn_data),
    .irq_req  (irq_req),
    .irq_clr  (irq_clr),
    .en       (en_q),
    .rise     (ack_rise)
);

// File: tb/prn_port_tb_top.sv
`timescale 1ns/1ps
module prn_port_tb_top;
    localparam int STB_N = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  prn_data;
    logic        prn_strobe_n;
    logic        prn_busy = 1'b0, prn_ack = 1'b0, prn_err = 1'b0;
    logic        ack_inv = 1'b0, irq_clr = 1'b0;
    logic        irq_req;

    int checks = 0, fails = 0;
    string phase = "R1";
    bit done = 0;

    always #4 clk = ~clk;

    prn_port #(.ADDR_W(16), .BASE(16'hFF40), .STB_CYCLES(STB_N)) dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prn_data(prn_data),
        .prn_strobe_n(prn_strobe_n), .prn_busy(prn_busy), .prn_ack(prn_ack),
        .prn_err(prn_err), .ack_inv(ack_inv), .irq_clr(irq_clr), .irq_req(irq_req)
    );

    // behavioural reference model
    bit [2:0] m_s1, m_s2;       // {err, ack, busy}
    bit       m_prev, m_en, m_pend, m_setup;
    int       m_remain;
    bit [7:0] m_data;

    always @(posedge clk) begin
        bit hit, cur, edge_seen, idle;
        if (rst) begin
            m_s1 = 0; m_s2 = 0; m_prev = 0; m_en = 0; m_pend = 0;
            m_setup = 0; m_remain = 0; m_data = 0;
        end else begin
            hit  = (bus_addr[15:4] == 12'hFF4);
            idle = !m_setup && (m_remain == 0);
            cur  = m_s2[1] ^ ack_inv;
            edge_seen = cur && !m_prev;
            if (!m_en)          m_pend = 0;
            else if (edge_seen) m_pend = 1;
            else if (irq_clr)   m_pend = 0;
            m_prev = cur;
            m_s2 = m_s1;
            m_s1 = {prn_err, prn_ack, prn_busy};
            if (bus_wr && hit && bus_addr[3:0] == 4'hC) m_en = bus_wdata[6];
            if (bus_wr && hit && bus_addr[3:0] == 4'hE && idle) m_data = bus_wdata[7:0];
            if (m_setup) begin
                m_setup = 0; m_remain = STB_N;
            end else if (m_remain > 0) begin
                m_remain--;
            end else if (bus_wr && hit && bus_addr[3:0] == 4'hF) begin
                m_setup = 1;
            end
        end
    end

    function automatic logic [15:0] exp_rdata();
        logic [15:0] st;
        st = {m_s2[2], 5'b0, m_s2[1], m_s2[0], m_pend, m_en, 6'b0};
        if (!bus_rd || bus_addr[15:4] != 12'hFF4) return 16'h0000;
        case (bus_addr[3:0])
            4'hC: return st;
            4'hD: return {8'h00, st[15:8]};
            4'hE: return {8'h00, m_data};
            default: return 16'h0000;
        endcase
    endfunction

    task automatic check(string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s at %0t: actual=%h expected=%h", phase, what, $time, act, exp);
        end
    endtask

    // compare away from the active edge, after inputs have settled
    always @(negedge clk) begin
        #3;
        if (!done) begin
            check("strobe_n", {15'b0, prn_strobe_n}, {15'b0, !(m_remain > 0)});
            check("data",     {8'b0, prn_data},      {8'b0, m_data});
            check("irq_req",  {15'b0, irq_req},      {15'b0, m_pend});
            check("rdata",    bus_rdata,             exp_rdata());
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [15:0] a, logic [15:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(logic [15:0] a);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic ack_pulse(int len);
        @(negedge clk);
        prn_ack = ~prn_ack;
        idle(len);
        prn_ack = ~prn_ack;
    endtask

    task automatic finish_run();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog expired in phase %s", phase);
        finish_run();
    end

    initial begin
        // R1: reset state
        phase = "R1";
        idle(4);
        rst = 1'b0;
        bus_read(16'hFF4C);
        // R3: data latch and readback
        phase = "R3";
        bus_write(16'hFF4E, 16'h12A5);
        bus_read(16'hFF4E);
        // R2: foreign base and unmapped offsets
        phase = "R2";
        bus_write(16'h1F4E, 16'h0077);
        bus_write(16'hFF50, 16'h00FF);
        bus_read(16'h1F4E);
        bus_read(16'hFF44);
        bus_read(16'hFF4E);
        // R4: strobe after trigger
        phase = "R4";
        bus_write(16'hFF4F, 16'h0000);
        idle(STB_N + 3);
        // R5: writes during the strobe sequence are ignored
        phase = "R5";
        bus_write(16'hFF4E, 16'h003C);
        bus_write(16'hFF4F, 16'h0000);
        bus_write(16'hFF4E, 16'h0099);
        bus_write(16'hFF4F, 16'h0000);
        idle(STB_N + 3);
        bus_write(16'hFF4E, 16'h003C);
        bus_read(16'hFF4E);
        // R6 / R7: status lines through the synchronizers
        phase = "R6";
        @(negedge clk); prn_busy = 1'b1; prn_err = 1'b1;
        bus_read(16'hFF4C);
        idle(2);
        bus_read(16'hFF4C);
        phase = "R7";
        bus_read(16'hFF4D);
        @(negedge clk); prn_busy = 1'b0;
        idle(3);
        bus_read(16'hFF4D);
        @(negedge clk); prn_err = 1'b0;
        // R11: acknowledge with enable clear
        phase = "R11";
        ack_pulse(3);
        idle(5);
        // R8: enable through 0xC, not 0xD
        phase = "R8";
        bus_write(16'hFF4D, 16'h0040);
        bus_read(16'hFF4C);
        bus_write(16'hFF4C, 16'h0040);
        bus_read(16'hFF4C);
        // R9: rising acknowledge sets request
        phase = "R9";
        ack_pulse(2);
        idle(5);
        bus_read(16'hFF4C);
        // R12: clear, then clear coinciding with an edge
        phase = "R12";
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        idle(2);
        @(negedge clk); prn_ack = 1'b1;
        idle(2);
        irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        idle(3);
        @(negedge clk); prn_ack = 1'b0;
        idle(3);
        // R11: disable drops pending
        phase = "R11";
        bus_write(16'hFF4C, 16'h0000);
        idle(2);
        bus_write(16'hFF4C, 16'h0040);
        // R10: inverted polarity, falling edge active
        phase = "R10";
        @(negedge clk); irq_clr = 1'b1; prn_ack = 1'b1; ack_inv = 1'b1;
        idle(5);
        irq_clr = 1'b0;
        idle(2);
        @(negedge clk); prn_ack = 1'b0;
        idle(5);
        @(negedge clk); irq_clr = 1'b1;
        @(negedge clk); irq_clr = 1'b0;
        @(negedge clk); prn_ack = 1'b1;
        idle(5);
        bus_read(16'hFF4C);
        // R4: second strobe with new data
        phase = "R4";
        bus_write(16'hFF4E, 16'h00C3);
        bus_write(16'hFF4F, 16'h0000);
        idle(STB_N + 4);
        finish_run();
    end
endmodule